// File: doc/BRIEF.md
# Stack Reference Address Translator

This block converts stack-relative variable references into absolute memory addresses. It accepts two kinds of reference. A lexical reference names a lexical level and an offset. The level picks one of the display registers, and each display register holds the absolute address of a procedure's mark-stack word. The offset is added to that address. A stuffed reference names a stack number, a displacement and an offset. The stack number picks an entry in the stack-vector table. Each entry holds the base address of one stack and a flag that says whether the stack is resident in memory. The result is the base plus the displacement plus the offset.

Both kinds of reference go through one shared three-input adder. Every lookup produces a registered response exactly one cycle later. The response carries the address and three fault flags: illegal level, absent stack and address overflow. A single write port loads either a display register or a stack-vector entry. A lookup issued in the same cycle as a write still sees the old contents. Keeping the display registers correct on procedure entry and exit is the job of surrounding logic.

Top module: `couple_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, and every stack-vector entry is marked absent until it is written with wr_present = 1.
- R2: rsp_valid is 1 in exactly the cycle after a cycle with req_valid = 1, and 0 after a cycle without a request.
- R3: A lexical reference (req_stuffed = 0) with req_ll <= cur_ll returns the display register selected by req_ll plus req_ofs.
- R4: A lexical reference with req_ll > cur_ll returns rsp_illegal = 1 and rsp_addr = 0. A level equal to cur_ll is legal.
- R5: A stuffed reference (req_stuffed = 1) to a present entry returns that entry's base + req_disp + req_ofs.
- R6: A stuffed reference to an absent entry returns rsp_absent = 1 and rsp_addr = 0. An absent stack is reported instead of an overflow, even when the sum would also overflow.
- R7: A sum above 2^AW-1 returns rsp_ovf = 1 and rsp_addr = 0. A sum of exactly 2^AW-1 is returned without a fault.
- R8: A write takes effect for lookups issued in the cycle after the write. A lookup issued in the same cycle as the write returns the old contents.
- R9: The write port is steered by wr_sel. With wr_sel = 0, the write goes to the display register numbered by the low log2(NDISP) bits of wr_idx. With wr_sel = 1, it goes to the stack-vector entry wr_idx, loading both its base and its presence flag. A write to one store leaves the other store unchanged.
- R10: A stuffed reference ignores req_ll and cur_ll, so it never reports rsp_illegal.
- R11: At most one of rsp_illegal, rsp_absent and rsp_ovf is 1 in any response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 = display register, 1 = stack-vector entry |
| wr_idx | input | SN_W (10) | Entry number; for a display write, only the low LL_W bits are used |
| wr_addr | input | AW (20) | Address value to store |
| wr_present | input | 1 | Presence flag for stack-vector writes |
| cur_ll | input | LL_W (5) | Lexical level of the running procedure |
| req_valid | input | 1 | Lookup request |
| req_stuffed | input | 1 | 0 = lexical reference, 1 = stuffed reference |
| req_ll | input | LL_W (5) | Lexical level of a lexical reference |
| req_stk | input | SN_W (10) | Stack number of a stuffed reference |
| req_disp | input | DISP_W (16) | Displacement of the mark-stack word in a stuffed reference |
| req_ofs | input | OFS_W (14) | Offset added in both kinds of reference |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_addr | output | AW (20) | Absolute address; 0 when any fault is flagged |
| rsp_illegal | output | 1 | Lexical level above the current level |
| rsp_absent | output | 1 | Target stack not resident |
| rsp_ovf | output | 1 | Address sum overflowed AW bits |

## Verification
The bench goes after several corner cases, and each has a distinct failure signature:

- **Level boundary.** Levels equal to and one above the current level are both tested. An off-by-one comparison would either reject the running procedure's own level or accept a dead display.
- **Overflow boundary.** Sums that land exactly on the top address and one past it are tested for both kinds of reference. A carry taken from the wrong bit would either fault on a valid address or wrap silently.
- **Absent plus overflow.** An absent stack whose base would also overflow is tested. A design with the wrong priority would raise the overflow flag or two flags at once.
- **Write-port timing and steering.** Same-cycle write-then-lookup pairs expose a write-through path. Display writes with large entry numbers show whether the index is truncated correctly, and whether a write leaks into the stack-vector table.

// File: rtl/couple_xlate_pkg.sv
package couple_xlate_pkg;

  // write port target selector
  typedef enum logic {
    WR_DISPLAY  = 1'b0,
    WR_STACKVEC = 1'b1
  } wr_target_e;

  // fault flags of one lookup
  typedef struct packed {
    logic illegal;
    logic absent;
    logic ovf;
  } fault_t;

endpackage

// File: rtl/cx_rst_sync.sv
module cx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/cx_display_file.sv
module cx_display_file #(
  parameter int AW    = 20,
  parameter int NDISP = 32,
  localparam int LL_W = $clog2(NDISP)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [LL_W-1:0] wr_idx,
  input  logic [AW-1:0]   wr_data,
  input  logic [LL_W-1:0] rd_idx,
  output logic [AW-1:0]   rd_data
);

  // storage holds no reset; software loads each level before use
  logic [AW-1:0] disp_q [NDISP];

  always_ff @(posedge clk) begin
    if (wr_en) disp_q[wr_idx] <= wr_data;
  end

  assign rd_data = disp_q[rd_idx];

endmodule

// File: rtl/cx_stack_table.sv
module cx_stack_table #(
  parameter int AW   = 20,
  parameter int NSTK = 1024,
  localparam int SN_W = $clog2(NSTK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SN_W-1:0] wr_idx,
  input  logic [AW-1:0]   wr_base,
  input  logic            wr_present,
  input  logic [SN_W-1:0] rd_idx,
  output logic [AW-1:0]   rd_base,
  output logic            rd_present
);

  logic [AW-1:0]   base_q [NSTK];
  logic [NSTK-1:0] pres_q;
  logic [NSTK-1:0] pres_d;

  // bases carry no reset, they are gated by the presence flags
  always_ff @(posedge clk) begin
    if (wr_en) base_q[wr_idx] <= wr_base;
  end

  always_comb begin
    pres_d = pres_q;
    if (wr_en) pres_d[wr_idx] = wr_present;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pres_q <= '0;
    else        pres_q <= pres_d;
  end

  assign rd_base    = base_q[rd_idx];
  assign rd_present = pres_q[rd_idx];

endmodule

// File: rtl/cx_addr_calc.sv
module cx_addr_calc
  import couple_xlate_pkg::*;
#(
  parameter int AW     = 20,
  parameter int LL_W   = 5,
  parameter int DISP_W = 16,
  parameter int OFS_W  = 14,
  localparam int SW    = AW + 2
) (
  input  logic              stuffed,
  input  logic [LL_W-1:0]   ll,
  input  logic [LL_W-1:0]   cur_ll,
  input  logic [AW-1:0]     disp_ptr,
  input  logic [AW-1:0]     stk_base,
  input  logic              stk_present,
  input  logic [DISP_W-1:0] disp,
  input  logic [OFS_W-1:0]  ofs,
  output logic [AW-1:0]     addr,
  output fault_t            fault
);

  logic [SW-1:0] op_a;
  logic [SW-1:0] op_b;
  logic [SW-1:0] sum;

  // one shared adder for both reference kinds
  always_comb begin
    op_a = stuffed ? SW'(stk_base) : SW'(disp_ptr);
    op_b = stuffed ? SW'(disp)     : '0;
    sum  = op_a + op_b + SW'(ofs);
  end

  always_comb begin
    fault.illegal = !stuffed && (ll > cur_ll);
    fault.absent  = stuffed && !stk_present;
    fault.ovf     = !fault.illegal && !fault.absent && (sum[SW-1:AW] != '0);
    addr          = (fault.illegal || fault.absent || fault.ovf) ? '0 : sum[AW-1:0];
  end

endmodule

// File: rtl/couple_xlate.sv
module couple_xlate
  import couple_xlate_pkg::*;
#(
  parameter int AW     = 20,
  parameter int NDISP  = 32,
  parameter int NSTK   = 1024,
  parameter int DISP_W = 16,
  parameter int OFS_W  = 14,
  localparam int LL_W  = $clog2(NDISP),
  localparam int SN_W  = $clog2(NSTK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [SN_W-1:0]   wr_idx,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_present,
  input  logic [LL_W-1:0]   cur_ll,
  input  logic              req_valid,
  input  logic              req_stuffed,
  input  logic [LL_W-1:0]   req_ll,
  input  logic [SN_W-1:0]   req_stk,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [OFS_W-1:0]  req_ofs,
  output logic              rsp_valid,
  output logic [AW-1:0]     rsp_addr,
  output logic              rsp_illegal,
  output logic              rsp_absent,
  output logic              rsp_ovf
);

  logic          rst_sync_n;
  logic          wr_disp_en;
  logic          wr_stk_en;
  logic [AW-1:0] disp_ptr;
  logic [AW-1:0] stk_base;
  logic          stk_present;
  logic [AW-1:0] calc_addr;
  fault_t        calc_fault;

  logic          valid_d, valid_q;
  logic [AW-1:0] addr_d, addr_q;
  fault_t        fault_d, fault_q;

  cx_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_disp_en = wr_en && (wr_target_e'(wr_sel) == WR_DISPLAY);
  assign wr_stk_en  = wr_en && (wr_target_e'(wr_sel) == WR_STACKVEC);

  cx_display_file #(.AW(AW), .NDISP(NDISP)) u_display (
    .clk     (clk),
    .wr_en   (wr_disp_en),
    .wr_idx  (wr_idx[LL_W-1:0]),
    .wr_data (wr_addr),
    .rd_idx  (req_ll),
    .rd_data (disp_ptr)
  );

  cx_stack_table #(.AW(AW), .NSTK(NSTK)) u_stack_table (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_stk_en),
    .wr_idx     (wr_idx),
    .wr_base    (wr_addr),
    .wr_present (wr_present),
    .rd_idx     (req_stk),
    .rd_base    (stk_base),
    .rd_present (stk_present)
  );

  cx_addr_calc #(.AW(AW), .LL_W(LL_W), .DISP_W(DISP_W), .OFS_W(OFS_W)) u_calc (
    .stuffed     (req_stuffed),
    .ll          (req_ll),
    .cur_ll      (cur_ll),
    .disp_ptr    (disp_ptr),
    .stk_base    (stk_base),
    .stk_present (stk_present),
    .disp        (req_disp),
    .ofs         (req_ofs),
    .addr        (calc_addr),
    .fault       (calc_fault)
  );

  // next state of the response stage; payload is loaded only on a request
  always_comb begin
    valid_d = req_valid;
    addr_d  = addr_q;
    fault_d = fault_q;
    if (req_valid) begin
      addr_d  = calc_addr;
      fault_d = calc_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      fault_q <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_d;
  end

  assign rsp_valid   = valid_q;
  assign rsp_addr    = addr_q;
  assign rsp_illegal = fault_q.illegal;
  assign rsp_absent  = fault_q.absent;
  assign rsp_ovf     = fault_q.ovf;

endmodule

// File: rtl/cx_checker.sv
module cx_checker #(
  parameter int AW   = 20,
  parameter int LL_W = 5
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            req_valid,
  input logic            req_stuffed,
  input logic [LL_W-1:0] req_ll,
  input logic [LL_W-1:0] cur_ll,
  input logic            rsp_valid,
  input logic [AW-1:0]   rsp_addr,
  input logic            rsp_illegal,
  input logic            rsp_absent,
  input logic            rsp_ovf
);

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);

  a_r11_single_fault: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> $onehot0({rsp_illegal, rsp_absent, rsp_ovf}));

  // R4, R6, R7: a faulted response carries a zero address
  a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && (rsp_illegal || rsp_absent || rsp_ovf)) |-> (rsp_addr == '0));

  a_r4_high_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_stuffed && (req_ll > cur_ll)) |=> rsp_illegal);

  a_r4_legal_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_stuffed && (req_ll <= cur_ll)) |=> !rsp_illegal && !rsp_absent);

  a_r10_stuffed_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_stuffed) |=> !rsp_illegal);

endmodule

bind couple_xlate cx_checker #(.AW(AW), .LL_W(LL_W)) u_cx_checker (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .req_valid   (req_valid),
  .req_stuffed (req_stuffed),
  .req_ll      (req_ll),
  .cur_ll      (cur_ll),
  .rsp_valid   (rsp_valid),
  .rsp_addr    (rsp_addr),
  .rsp_illegal (rsp_illegal),
  .rsp_absent  (rsp_absent),
  .rsp_ovf     (rsp_ovf)
);

// File: tb/couple_xlate_tb_top.sv
module couple_xlate_tb_top;

  localparam int AW = 20, NDISP = 32, NSTK = 1024, DISP_W = 16, OFS_W = 14;
  localparam int LL_W = 5, SN_W = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en, wr_sel, wr_present;
  logic [SN_W-1:0]   wr_idx;
  logic [AW-1:0]     wr_addr;
  logic [LL_W-1:0]   cur_ll;
  logic              req_valid, req_stuffed;
  logic [LL_W-1:0]   req_ll;
  logic [SN_W-1:0]   req_stk;
  logic [DISP_W-1:0] req_disp;
  logic [OFS_W-1:0]  req_ofs;
  logic              rsp_valid, rsp_illegal, rsp_absent, rsp_ovf;
  logic [AW-1:0]     rsp_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [AW-1:0] disp_m [NDISP];
  logic [AW-1:0] base_m [NSTK];
  bit            pres_m [NSTK];

  always #5 clk = ~clk;

  couple_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_addr(wr_addr), .wr_present(wr_present), .cur_ll(cur_ll),
    .req_valid(req_valid), .req_stuffed(req_stuffed), .req_ll(req_ll),
    .req_stk(req_stk), .req_disp(req_disp), .req_ofs(req_ofs),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_illegal(rsp_illegal),
    .rsp_absent(rsp_absent), .rsp_ovf(rsp_ovf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model(input bit st, input int ll, input int stk, input int dsp,
                                input int ofs, output logic [AW-1:0] a,
                                output bit il, output bit ab, output bit ov);
    longint s = 0;
    a = '0; il = 0; ab = 0; ov = 0;
    if (!st) begin
      if (ll > int'(cur_ll)) il = 1;
      else s = longint'(disp_m[ll]) + ofs;
    end else begin
      if (!pres_m[stk]) ab = 1;
      else s = longint'(base_m[stk]) + dsp + ofs;
    end
    if (!il && !ab) begin
      if (s > longint'(2**AW - 1)) ov = 1;
      else a = s[AW-1:0];
    end
  endfunction

  // update the model after a write has been clocked in
  function automatic void commit(input bit sel, input int idx, input logic [AW-1:0] a, input bit p);
    if (!sel) disp_m[idx % NDISP] = a;
    else begin
      base_m[idx] = a;
      pres_m[idx] = p;
    end
  endfunction

  task automatic drive_req(input bit st, input int ll, input int stk, input int dsp, input int ofs);
    req_valid = 1; req_stuffed = st;
    req_ll = LL_W'(ll); req_stk = SN_W'(stk); req_disp = DISP_W'(dsp); req_ofs = OFS_W'(ofs);
  endtask

  task automatic check_rsp(input string req, input logic [AW-1:0] a, input bit il, input bit ab, input bit ov);
    chk(req, 64'(rsp_valid), 64'd1);
    chk(req, {44'd0, rsp_addr}, {44'd0, a});
    chk(req, {61'd0, rsp_illegal, rsp_absent, rsp_ovf}, {61'd0, il, ab, ov});
  endtask

  // lookup: drive at a falling edge, check at the next falling edge
  task automatic lookup(input string req, input bit st, input int ll, input int stk,
                        input int dsp, input int ofs);
    logic [AW-1:0] a; bit il, ab, ov;
    model(st, ll, stk, dsp, ofs, a, il, ab, ov);
    drive_req(st, ll, stk, dsp, ofs);
    @(negedge clk);
    req_valid = 0;
    check_rsp(req, a, il, ab, ov);
  endtask

  task automatic write(input bit sel, input int idx, input logic [AW-1:0] a, input bit p);
    wr_en = 1; wr_sel = sel; wr_idx = SN_W'(idx); wr_addr = a; wr_present = p;
    @(negedge clk);
    wr_en = 0;
    commit(sel, idx, a, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a; bit il, ab, ov;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NSTK; i++) begin base_m[i] = '0; pres_m[i] = 0; end
    for (int i = 0; i < NDISP; i++) disp_m[i] = '0;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_idx = '0; wr_addr = '0; wr_present = 0;
    cur_ll = '0; req_valid = 0; req_stuffed = 0; req_ll = '0; req_stk = '0;
    req_disp = '0; req_ofs = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 valid after reset", 64'(rsp_valid), 64'd0);
    lookup("R1 absent after reset", 1, 0, 517, 3, 4);
    lookup("R1 absent after reset", 1, 0, 0, 0, 0);

    // load stores
    for (int i = 0; i < NDISP; i++) write(0, i, AW'($urandom()), 0);
    for (int i = 0; i < NSTK; i++) write(1, i, AW'($urandom()), ($urandom_range(7) != 0));

    // R2: idle cycle gives no response
    @(negedge clk);
    chk("R2 idle", 64'(rsp_valid), 64'd0);

    // R3 / R4 level boundary
    cur_ll = 5;
    write(0, 3, 20'h01000, 0);
    lookup("R3 normal", 0, 3, 0, 0, 5);
    lookup("R4 level equal", 0, 5, 0, 0, 9);
    lookup("R4 level above", 0, 6, 0, 0, 9);
    // R10: stuffed ignores levels
    cur_ll = 0;
    write(1, 200, 20'h00400, 1);
    lookup("R10 stuffed high ll", 1, 31, 200, 16, 1);
    // R7 boundary, lexical form
    cur_ll = 31;
    write(0, 7, 20'hFFFF0, 0);
    lookup("R7 lexical max", 0, 7, 0, 0, 15);
    lookup("R7 lexical over", 0, 7, 0, 0, 16);
    // R5 / R7 stuffed form
    write(1, 100, 20'hFFF00, 1);
    lookup("R5 stuffed max", 1, 0, 100, 16'h80, 14'h7F);
    lookup("R7 stuffed over", 1, 0, 100, 16'h80, 14'h80);
    // R6 absent wins over overflow
    write(1, 101, 20'hFFFFF, 0);
    lookup("R6 absent over ovf", 1, 0, 101, 16'hFFFF, 1);
    write(1, 101, 20'h00010, 1);
    lookup("R6 made present", 1, 0, 101, 2, 3);
    write(1, 101, 20'h00010, 0);
    lookup("R6 marked absent again", 1, 0, 101, 2, 3);

    // R8: write and lookup in the same cycle see old data
    wr_en = 1; wr_sel = 0; wr_idx = 10'd9; wr_addr = 20'h22222; wr_present = 0;
    model(0, 9, 0, 0, 1, a, il, ab, ov);
    drive_req(0, 9, 0, 0, 1);
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    check_rsp("R8 same cycle old", a, il, ab, ov);
    commit(0, 9, 20'h22222, 0);
    lookup("R8 next cycle new", 0, 9, 0, 0, 1);

    // R9: display write uses low index bits, stack table untouched
    write(1, 100, 20'h12340, 1);
    write(0, 100, 20'h05550, 0);
    lookup("R9 display index trunc", 0, 4, 0, 0, 2);
    lookup("R9 table untouched", 1, 0, 100, 0, 2);
    write(1, 4, 20'h77770, 1);
    lookup("R9 display untouched", 0, 4, 0, 0, 2);

    // random mix with back-to-back lookups
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(7) == 0)
        write($urandom_range(1), $urandom_range(NSTK-1), AW'($urandom()), ($urandom_range(3) != 0));
      cur_ll = LL_W'($urandom_range(31));
      if ($urandom_range(1) == 0)
        lookup("R3 R4 R7 random lexical", 0, $urandom_range(31), $urandom_range(NSTK-1),
               $urandom_range(65535), $urandom_range(16383));
      else
        lookup("R5 R6 R7 R10 random stuffed", 1, $urandom_range(31), $urandom_range(NSTK-1),
               $urandom_range(65535), $urandom_range(16383));
    end
    @(negedge clk);
    chk("R2 idle at end", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule